// File: doc/BRIEF.md
# Cascaded Search Hit Arbiter

This block sits in each search device of a depth-cascaded table, in which several devices are grouped into blocks and all devices share one external result SRAM. Every device receives the same search command at the same time. Each device also receives its own match result and a flag that shows whether a higher-priority device in its own block matched. The block has two jobs. It broadcasts a block-hit indication a fixed number of cycles after each search. It also decides whether this device, and no other, may drive the SRAM address and control lines for that search.

Each block reports its hit on a three-bit bus. Only the last device of a block drives that bus, because that device sees the combined chain result of the whole block. Every device in a downstream block receives the bus on its block-hit inputs. A device holds the SRAM for a search only when three things are true: it matched locally, nothing above it in its own block matched, and no upstream block reported a hit in the arbitration cycle. Upstream hits count only when the table-size field selects the multi-block setting (2'b10). In any other setting the device acts as the only block and ignores the bus. The lowest block has its block-hit inputs tied low. Searches may arrive on back-to-back cycles, and each search in flight keeps its own decision.

Top module: `cascade_hit_arbiter`

## Requirements
- R1: While `rst_n` is low, and after reset until a search reaches the output stage, `blk_hit_out` is 3'b000 and `sram_grant` is 0.
- R2: The block-hit value is 3'b111 when the accepted search had `local_match` or `chain_hit_in` set on a device with `cfg_last_dev` high. Otherwise it is 3'b000. The three bits never differ.
- R3: A search is accepted when `srch_valid` is high at a rising edge. Its block-hit value appears on `blk_hit_out` in the cycle after the LATENCY-th rising edge, counting the accepting edge as the first (LATENCY = 5). It lasts one cycle. Searches on consecutive cycles give independent results on consecutive cycles.
- R4: With `cfg_last_dev` low, `blk_hit_oe` is 0 and `blk_hit_out` is 3'b000. With `cfg_last_dev` high, `blk_hit_oe` is 1.
- R5: `sram_grant` is 1 for a search only when that search had `local_match` high and `chain_hit_in` low.
- R6: When `cfg_tsize` is 2'b10, the grant is withheld if any bit of `blk_hit_in` is high at the arbitration edge. That edge is the rising edge that ends the search's block-hit cycle. Every bit position has the same effect.
- R7: When `cfg_tsize` is not 2'b10, `blk_hit_in` has no effect on `sram_grant`.
- R8: `sram_grant` for a search rises at the arbitration edge, one cycle after the block-hit value, and lasts one cycle.
- R9: Driving `rst_n` low clears both outputs at once, without a clock edge. Release is synchronised over two edges, and afterwards searches are handled normally again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_last_dev | input | 1 | Device is the last one of its block and drives the block-hit bus |
| cfg_tsize | input | 2 | Table-size field; 2'b10 selects multi-block cascading |
| srch_valid | input | 1 | Search command accepted this edge |
| local_match | input | 1 | This device matched the search |
| chain_hit_in | input | 1 | A higher device in the same block matched |
| blk_hit_in | input | 3 | Block-hit indications from upstream blocks |
| blk_hit_out | output | 3 | Block-hit broadcast (meaningful when enabled) |
| blk_hit_oe | output | 1 | Output enable for the block-hit bus |
| sram_grant | output | 1 | This device drives the shared SRAM for the search |

## Verification
The bench sweeps every configuration of last-device flag and table-size value. It runs both fully back-to-back and sparse search streams with pseudo-random match, chain and upstream-hit patterns. The sparse streams catch a pipeline that is one stage off or that merges neighbouring searches, because those faults show up as shifted or smeared hits. Upstream hits are applied on every bit position at exactly the arbitration edge. A design that samples the bus one cycle early or late, or that honours it outside the cascade setting, loses or wrongly keeps grants. A reset is also applied while the pipeline is full. This catches state that survives an asynchronous reset and a release that is not synchronised.

// File: rtl/cha_pkg.sv
package cha_pkg;
  // one in-flight search as it moves through the latency pipeline
  typedef struct packed {
    logic vld;   // a search occupies this slot
    logic cand;  // device may claim the SRAM (local hit, no chain hit)
    logic bhit;  // block reports a hit for this search
  } cha_slot_t;
endpackage

// File: rtl/cha_rst_sync.sv
module cha_rst_sync (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic meta_d;
  logic sync_q;
  logic sync_d;

  always_comb begin
    meta_d = 1'b1;
    sync_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/cha_pipe.sv
module cha_pipe
  import cha_pkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  cha_slot_t in_slot,
  output cha_slot_t out_slot
);
  localparam int LAST = DEPTH - 1;

  cha_slot_t stage_q [DEPTH];
  cha_slot_t stage_d [DEPTH];
  logic      stage_en [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_comb begin
        stage_d[i]  = in_slot;
        stage_en[i] = in_slot.vld | stage_q[i].vld;
      end
    end else begin : g_body
      always_comb begin
        stage_d[i]  = stage_q[i-1];
        stage_en[i] = stage_q[i-1].vld | stage_q[i].vld;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[i] <= '0;
      end else if (stage_en[i]) begin
        stage_q[i] <= stage_d[i];
      end
    end
  end

  assign out_slot = stage_q[LAST];

  // R5
  slot_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_slot.vld |-> (!out_slot.cand && !out_slot.bhit));
endmodule

// File: rtl/cha_bho_drv.sv
module cha_bho_drv #(
  parameter int BH_W = 3
) (
  input  logic            cfg_last_dev,
  input  logic            slot_vld,
  input  logic            slot_bhit,
  output logic [BH_W-1:0] bho_val,
  output logic            bho_oe
);
  always_comb begin
    bho_oe  = cfg_last_dev;
    bho_val = {BH_W{cfg_last_dev & slot_vld & slot_bhit}};
  end
endmodule

// File: rtl/cha_grant.sv
module cha_grant #(
  parameter int              BH_W        = 3,
  parameter int              TSZ_W       = 2,
  parameter logic [TSZ_W-1:0] TSZ_CASCADE = 2'b10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_vld,
  input  logic             slot_cand,
  input  logic [BH_W-1:0]  blk_hit_in,
  input  logic [TSZ_W-1:0] cfg_tsize,
  output logic             sram_grant
);
  logic cascade_mode;
  logic upstream_hit;
  logic grant_d;
  logic grant_q;
  logic grant_en;

  always_comb begin
    cascade_mode = (cfg_tsize == TSZ_CASCADE);
    upstream_hit = cascade_mode & (|blk_hit_in);
    grant_d      = slot_vld & slot_cand & ~upstream_hit;
    grant_en     = grant_d | grant_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
    end else if (grant_en) begin
      grant_q <= grant_d;
    end
  end

  assign sram_grant = grant_q;

  // R6
  upstream_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_tsize == TSZ_CASCADE) && (|blk_hit_in)) |=> !sram_grant);

  // R7
  solo_ignores_upstream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_tsize != TSZ_CASCADE) && slot_vld && slot_cand) |=> sram_grant);

  // R5
  grant_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_grant |-> $past(slot_vld && slot_cand));
endmodule

// File: rtl/cascade_hit_arbiter.sv
module cascade_hit_arbiter
  import cha_pkg::*;
#(
  parameter int               LATENCY     = 5,
  parameter int               BH_W        = 3,
  parameter int               TSZ_W       = 2,
  parameter logic [TSZ_W-1:0] TSZ_CASCADE = 2'b10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_last_dev,
  input  logic [TSZ_W-1:0] cfg_tsize,
  input  logic             srch_valid,
  input  logic             local_match,
  input  logic             chain_hit_in,
  input  logic [BH_W-1:0]  blk_hit_in,
  output logic [BH_W-1:0]  blk_hit_out,
  output logic             blk_hit_oe,
  output logic             sram_grant
);
  localparam int PIPE_DEPTH = (LATENCY < 1) ? 1 : LATENCY;

  logic      rst_sync_n;
  cha_slot_t head_slot;
  cha_slot_t tail_slot;

  cha_rst_sync u_rst (
    .clk        (clk),
    .rst_async_n(rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    head_slot.vld  = srch_valid;
    head_slot.cand = srch_valid & local_match & ~chain_hit_in;
    head_slot.bhit = srch_valid & (local_match | chain_hit_in);
  end

  cha_pipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .in_slot (head_slot),
    .out_slot(tail_slot)
  );

  cha_bho_drv #(.BH_W(BH_W)) u_bho (
    .cfg_last_dev(cfg_last_dev),
    .slot_vld    (tail_slot.vld),
    .slot_bhit   (tail_slot.bhit),
    .bho_val     (blk_hit_out),
    .bho_oe      (blk_hit_oe)
  );

  cha_grant #(.BH_W(BH_W), .TSZ_W(TSZ_W), .TSZ_CASCADE(TSZ_CASCADE)) u_grant (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .slot_vld  (tail_slot.vld),
    .slot_cand (tail_slot.cand),
    .blk_hit_in(blk_hit_in),
    .cfg_tsize (cfg_tsize),
    .sram_grant(sram_grant)
  );

  // R2
  bho_all_bits_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (blk_hit_out != '0) |-> (blk_hit_out == '1));

  // R4
  bho_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !blk_hit_oe |-> (blk_hit_out == '0));

  // R8
  grant_follows_slot_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tail_slot.vld && !tail_slot.cand) |=> !sram_grant);
endmodule

// File: tb/cascade_hit_arbiter_test.sv
module cascade_hit_arbiter_test;
  localparam int L = 5;
  localparam int N = 96;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_last_dev;
  logic [1:0] cfg_tsize;
  logic       srch_valid;
  logic       local_match;
  logic       chain_hit_in;
  logic [2:0] blk_hit_in;
  logic [2:0] blk_hit_out;
  logic       blk_hit_oe;
  logic       sram_grant;

  int checks = 0;
  int fails  = 0;
  logic [15:0] lfsr = 16'hACE1;

  bit       sv_a [0:255];
  bit       lm_a [0:255];
  bit       ch_a [0:255];
  bit [2:0] bi_a [0:255];

  always #2 clk = ~clk;

  cascade_hit_arbiter uut (
    .clk(clk), .rst_n(rst_n), .cfg_last_dev(cfg_last_dev), .cfg_tsize(cfg_tsize),
    .srch_valid(srch_valid), .local_match(local_match), .chain_hit_in(chain_hit_in),
    .blk_hit_in(blk_hit_in), .blk_hit_out(blk_hit_out), .blk_hit_oe(blk_hit_oe),
    .sram_grant(sram_grant)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic idle_inputs();
    srch_valid = 1'b0; local_match = 1'b0; chain_hit_in = 1'b0; blk_hit_in = 3'b000;
  endtask

  task automatic run_phase(bit last, logic [1:0] tsz, bit dense);
    idle_inputs();
    repeat (L + 2) @(negedge clk);
    cfg_last_dev = last;
    cfg_tsize    = tsz;
    for (int e = 0; e < N; e++) begin
      step_lfsr();
      sv_a[e] = dense ? 1'b1 : (lfsr[2:0] > 3'd3);
      lm_a[e] = lfsr[5];
      ch_a[e] = lfsr[7] & lfsr[8];
      bi_a[e] = lfsr[11] ? (3'b001 << (lfsr[14:13] % 3)) : (lfsr[10] ? lfsr[15:13] : 3'b000);
      srch_valid = sv_a[e]; local_match = lm_a[e];
      chain_hit_in = ch_a[e]; blk_hit_in = bi_a[e];
      @(posedge clk);
      @(negedge clk);
      begin
        int c  = e - L + 1;
        int g  = e - L;
        int eb = 0;
        int eg = 0;
        if (c >= 0 && sv_a[c] && (lm_a[c] || ch_a[c]) && last) eb = 7;
        if (g >= 0 && sv_a[g] && lm_a[g] && !ch_a[g] &&
            !(tsz == 2'b10 && bi_a[e] != 3'b000)) eg = 1;
        // R2 R3 block-hit value and latency
        check("R2", int'(blk_hit_out), eb);
        // R4 output enable follows last-device flag
        check("R4", int'(blk_hit_oe), int'(last));
        // R5 R6 R7 R8 grant decision
        if (tsz == 2'b10) check("R6", int'(sram_grant), eg);
        else              check("R7", int'(sram_grant), eg);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_last_dev = 1'b1;
    cfg_tsize = 2'b10;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R1 outputs clear while in reset
    check("R1", int'(blk_hit_out), 0);
    check("R1", int'(sram_grant), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", int'(blk_hit_out), 0);
    check("R1", int'(sram_grant), 0);

    // R3 single directed search, exact latency
    srch_valid = 1'b1; local_match = 1'b1;
    @(negedge clk);
    idle_inputs();
    for (int k = 2; k <= L + 1; k++) begin
      @(negedge clk);
      if (k < L) check("R3", int'(blk_hit_out), 0);
      if (k == L) check("R3", int'(blk_hit_out), 7);
      if (k == L) check("R8", int'(sram_grant), 0);
      if (k == L + 1) begin
        check("R3", int'(blk_hit_out), 0);
        check("R8", int'(sram_grant), 1);
      end
    end

    for (int m = 0; m < 16; m++) begin
      run_phase(m[0], m[2:1], m[3]);
    end

    // R9 asynchronous clear with a full pipeline
    idle_inputs();
    repeat (L + 2) @(negedge clk);
    cfg_last_dev = 1'b1; cfg_tsize = 2'b00;
    srch_valid = 1'b1; local_match = 1'b1;
    repeat (L + 2) @(negedge clk);
    check("R9", int'(blk_hit_out), 7);
    check("R9", int'(sram_grant), 1);
    #1 rst_n = 1'b0;
    #0.5;
    check("R9", int'(blk_hit_out), 0);
    check("R9", int'(sram_grant), 0);
    repeat (3) @(negedge clk);
    check("R1", int'(blk_hit_out), 0);
    idle_inputs();
    rst_n = 1'b1;
    @(negedge clk);
    // release still synchronising: a search now is not accepted
    srch_valid = 1'b1; local_match = 1'b1;
    @(negedge clk);
    idle_inputs();
    repeat (L + 1) @(negedge clk);
    check("R9", int'(blk_hit_out), 0);
    check("R9", int'(sram_grant), 0);
    run_phase(1'b1, 2'b10, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule